// File: doc/BRIEF.md
# Colour Channel Sequencer

This block chooses which of three colour inputs a shared converter works on during each cycle of the converter sample clock. It also presents the gain and offset codes for that channel. In three-channel mode the selection steps red, green, blue, red on every clock edge, so that one converter serves three inputs at three times the pixel rate. An active-low line-start input realigns the rotation to red at the start of each scan line. In single-channel mode the selection stays on one colour taken from a configuration field. An active-low external-control pin can take over the selection from two colour pins at any time.

The converter's output lags its input by two sample clocks, so the block tags each output word with the colour that was selected two edges earlier. A separate active-low test control, with its own two select pins, picks which channel is routed to a test observation point. The colour codes are red 00, green 01 and blue 10. Code 11 is reserved. When any active source presents 11, the affected selection keeps its last valid value and an error flag is raised.

Top module: `colour_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `colorIdx` and `tagColor` are 00, and `colorErr` and `testOn` are 0.
- R2: With `extCtlN` high, `threeChanMode` high and line-start inactive, `colorIdx` advances on each rising edge in the order 00, 01, 10, 00.
- R3: `lineStartN` is registered once on the clock. A low value captured at edge k forces `colorIdx` to 00 at edge k+1, and at every later edge while the registered copy stays low. Rotation resumes one edge after a high value has been captured.
- R4: With `extCtlN` high and `threeChanMode` low, `colorIdx` takes `cfgColor` at the next edge, and `lineStartN` has no effect.
- R5: With `extCtlN` low, `colorIdx` takes `extColor` at the next edge. This overrides both modes and line-start.
- R6: If the active colour source presents 11, `colorIdx` keeps its value at the next edge and `colorErr` is 1 for that cycle. When every active source is valid, `colorErr` is 0 after the next edge. `colorIdx` is never 11.
- R7: After each edge, `tagColor` equals the value `colorIdx` held two edges earlier.
- R8: `gainCode` is field `colorIdx` of `gainRegs` and `offsetCode` is field `colorIdx` of `offsetRegs`, where field i occupies bits [i*W +: W].
- R9: With `testCtlN` low, `testChan` takes `testSel` at the next edge and `testOn` is 1. A select of 11 keeps `testChan` and raises `colorErr`. With `testCtlN` high, `testOn` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lineStartN | input | 1 | Line start, active low |
| threeChanMode | input | 1 | 1: rotate three colours, 0: fixed colour |
| cfgColor | input | 2 | Fixed colour for single-channel mode |
| extCtlN | input | 1 | External colour override, active low |
| extColor | input | 2 | Colour used under override |
| testCtlN | input | 1 | Test routing enable, active low |
| testSel | input | 2 | Channel routed to the test point |
| gainRegs | input | 3*GAIN_W | Packed per-channel gain codes |
| offsetRegs | input | 3*OFFS_W | Packed per-channel offset codes |
| colorIdx | output | 2 | Current colour selection |
| gainCode | output | GAIN_W | Gain code of the current colour |
| offsetCode | output | OFFS_W | Offset code of the current colour |
| tagColor | output | 2 | Colour of the sample now leaving the converter |
| colorErr | output | 1 | Reserved code seen on an active source |
| testChan | output | 2 | Channel routed to the test point |
| testOn | output | 1 | Test routing active |

## Verification
The hardest case is the one-edge lag that registering line-start adds. Around the release of line-start, the rotation must advance once after line-start falls, sit on red, and stay on red for one more edge after line-start rises. Only then does it move to green. The bench drops line-start in the middle of a rotation and checks every edge through the fall and the release against the expected colour and the two-edge-delayed tag. Reserved codes are applied in turn through the override pins, the configuration field and the test select, so that the hold behaviour of each source is seen at the ports.

// File: rtl/colour_seq_pkg.sv
package colour_seq_pkg;
  typedef enum logic [1:0] {
    COL_RED   = 2'd0,
    COL_GREEN = 2'd1,
    COL_BLUE  = 2'd2,
    COL_RSVD  = 2'd3
  } colour_e;

  localparam int NUM_CHAN  = 3;
  localparam int NUM_SLOT  = 4;
  localparam int TAG_DEPTH = 2;

  typedef struct packed {
    logic forceRed;
    logic advance;
    logic loadExt;
    logic loadCfg;
    logic loadTest;
    logic errNow;
  } seqStrobe_t;
endpackage

// File: rtl/colour_seq_ctrl.sv
module colour_seq_ctrl
  import colour_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lineStartN,
  input  logic       threeChanMode,
  input  logic [1:0] cfgColor,
  input  logic       extCtlN,
  input  logic [1:0] extColor,
  input  logic       testCtlN,
  input  logic [1:0] testSel,
  output seqStrobe_t strobe
);
  logic lsSync;
  logic extValid, cfgValid, testValid;

  // line start captured once to meet its setup/hold window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lsSync <= 1'b1;
    else        lsSync <= lineStartN;
  end

  assign extValid  = (extColor != COL_RSVD);
  assign cfgValid  = (cfgColor != COL_RSVD);
  assign testValid = (testSel  != COL_RSVD);

  always_comb begin
    strobe = '0;
    if (!extCtlN)            strobe.loadExt  = extValid;
    else if (!threeChanMode) strobe.loadCfg  = cfgValid;
    else if (!lsSync)        strobe.forceRed = 1'b1;
    else                     strobe.advance  = 1'b1;
    strobe.loadTest = !testCtlN && testValid;
    strobe.errNow   = (!extCtlN && !extValid)
                   || (extCtlN && !threeChanMode && !cfgValid)
                   || (!testCtlN && !testValid);
  end
endmodule

// File: rtl/colour_seq_dp.sv
module colour_seq_dp
  import colour_seq_pkg::*;
#(
  parameter int GAIN_W = 5,
  parameter int OFFS_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  seqStrobe_t                 strobe,
  input  logic [1:0]                 cfgColor,
  input  logic [1:0]                 extColor,
  input  logic [1:0]                 testSel,
  input  logic                       testCtlN,
  input  logic [NUM_CHAN*GAIN_W-1:0] gainRegs,
  input  logic [NUM_CHAN*OFFS_W-1:0] offsetRegs,
  output logic [1:0]                 colorIdx,
  output logic [1:0]                 tagColor,
  output logic [GAIN_W-1:0]          gainCode,
  output logic [OFFS_W-1:0]          offsetCode,
  output logic                       colorErr,
  output logic [1:0]                 testChan,
  output logic                       testOn
);
  logic [1:0] colorNext;
  logic [1:0] tagPipe [TAG_DEPTH];
  logic [GAIN_W-1:0] gainField [NUM_SLOT];
  logic [OFFS_W-1:0] offsField [NUM_SLOT];

  always_comb begin
    colorNext = colorIdx;
    if (strobe.loadExt)       colorNext = extColor;
    else if (strobe.loadCfg)  colorNext = cfgColor;
    else if (strobe.forceRed) colorNext = COL_RED;
    else if (strobe.advance)  colorNext = (colorIdx == COL_BLUE) ? COL_RED : colorIdx + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colorIdx <= COL_RED;
      colorErr <= 1'b0;
      testChan <= COL_RED;
      testOn   <= 1'b0;
    end else begin
      colorIdx <= colorNext;
      colorErr <= strobe.errNow;
      testOn   <= !testCtlN;
      if (strobe.loadTest) testChan <= testSel;
    end
  end

  // colour tag follows the converter's pipeline
  for (genvar s = 0; s < TAG_DEPTH; s++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tagPipe[s] <= COL_RED;
      else if (s == 0) tagPipe[s] <= colorIdx;
      else             tagPipe[s] <= tagPipe[(s == 0) ? 0 : s-1];
    end
  end
  assign tagColor = tagPipe[TAG_DEPTH-1];

  for (genvar c = 0; c < NUM_SLOT; c++) begin : g_field
    if (c < NUM_CHAN) begin : g_live
      assign gainField[c] = gainRegs[c*GAIN_W +: GAIN_W];
      assign offsField[c] = offsetRegs[c*OFFS_W +: OFFS_W];
    end else begin : g_void
      assign gainField[c] = '0;
      assign offsField[c] = '0;
    end
  end
  assign gainCode   = gainField[colorIdx];
  assign offsetCode = offsField[colorIdx];
endmodule

// File: rtl/colour_seq.sv
module colour_seq
  import colour_seq_pkg::*;
#(
  parameter int GAIN_W = 5,
  parameter int OFFS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lineStartN,
  input  logic                  threeChanMode,
  input  logic [1:0]            cfgColor,
  input  logic                  extCtlN,
  input  logic [1:0]            extColor,
  input  logic                  testCtlN,
  input  logic [1:0]            testSel,
  input  logic [3*GAIN_W-1:0]   gainRegs,
  input  logic [3*OFFS_W-1:0]   offsetRegs,
  output logic [1:0]            colorIdx,
  output logic [GAIN_W-1:0]     gainCode,
  output logic [OFFS_W-1:0]     offsetCode,
  output logic [1:0]            tagColor,
  output logic                  colorErr,
  output logic [1:0]            testChan,
  output logic                  testOn
);
  seqStrobe_t strobe;

  colour_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .lineStartN(lineStartN),
    .threeChanMode(threeChanMode), .cfgColor(cfgColor),
    .extCtlN(extCtlN), .extColor(extColor),
    .testCtlN(testCtlN), .testSel(testSel), .strobe(strobe)
  );

  colour_seq_dp #(.GAIN_W(GAIN_W), .OFFS_W(OFFS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .cfgColor(cfgColor), .extColor(extColor), .testSel(testSel),
    .testCtlN(testCtlN), .gainRegs(gainRegs), .offsetRegs(offsetRegs),
    .colorIdx(colorIdx), .tagColor(tagColor), .gainCode(gainCode),
    .offsetCode(offsetCode), .colorErr(colorErr),
    .testChan(testChan), .testOn(testOn)
  );
endmodule

// File: rtl/colour_seq_chk.sv
module colour_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lineStartN,
  input logic       threeChanMode,
  input logic [1:0] cfgColor,
  input logic       extCtlN,
  input logic [1:0] extColor,
  input logic [1:0] colorIdx,
  input logic [1:0] tagColor,
  input logic       colorErr
);
  logic [1:0] upCnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             upCnt <= 2'd0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end
  assign warm = (upCnt == 2'd2);

  assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && extCtlN && threeChanMode && $past(lineStartN))
      |=> (colorIdx == (($past(colorIdx) == 2'd2) ? 2'd0 : $past(colorIdx) + 2'd1)));

  assert_line_red_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (extCtlN && threeChanMode && !lineStartN) ##1 (extCtlN && threeChanMode)
      |=> (colorIdx == 2'd0));

  assert_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (extCtlN && !threeChanMode && cfgColor != 2'd3) |=> (colorIdx == $past(cfgColor)));

  assert_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!extCtlN && extColor != 2'd3) |=> (colorIdx == $past(extColor)));

  assert_ext_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!extCtlN && extColor == 2'd3) |=> (colorErr && $stable(colorIdx)));

  assert_no_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (colorIdx != 2'd3));

  assert_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (tagColor == $past(colorIdx, 2)));
endmodule

bind colour_seq colour_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lineStartN(lineStartN),
  .threeChanMode(threeChanMode), .cfgColor(cfgColor),
  .extCtlN(extCtlN), .extColor(extColor),
  .colorIdx(colorIdx), .tagColor(tagColor), .colorErr(colorErr)
);

// File: tb/colour_seq_test.sv
module colour_seq_test;
  localparam int PERIOD = 10;
  localparam int GW = 5;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lineStartN = 1'b1, threeChanMode = 1'b1, extCtlN = 1'b1, testCtlN = 1'b1;
  logic [1:0] cfgColor = 2'd0, extColor = 2'd0, testSel = 2'd0;
  logic [3*GW-1:0] gainRegs = {5'd21, 5'd12, 5'd3};
  logic [3*OW-1:0] offsetRegs = {8'hC4, 8'h5A, 8'h17};
  logic [1:0] colorIdx, tagColor, testChan;
  logic [GW-1:0] gainCode;
  logic [OW-1:0] offsetCode;
  logic colorErr, testOn;

  int nRun = 0, nFail = 0;
  bit done = 0;
  int h1 = 0, h2 = 0;

  always #(PERIOD/2) clk = ~clk;

  colour_seq uut (
    .clk(clk), .rst_n(rst_n), .lineStartN(lineStartN),
    .threeChanMode(threeChanMode), .cfgColor(cfgColor),
    .extCtlN(extCtlN), .extColor(extColor), .testCtlN(testCtlN),
    .testSel(testSel), .gainRegs(gainRegs), .offsetRegs(offsetRegs),
    .colorIdx(colorIdx), .gainCode(gainCode), .offsetCode(offsetCode),
    .tagColor(tagColor), .colorErr(colorErr), .testChan(testChan),
    .testOn(testOn)
  );

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one edge, inputs and checks both at the falling edge
  task automatic tick();
    h2 = h1;
    h1 = colorIdx;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tickTag(input string req);
    tick();
    check(req, tagColor, h2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 colour in reset", colorIdx, 0);
    check("R1 tag in reset", tagColor, 0);
    check("R1 err in reset", colorErr, 0);
    check("R1 testOn in reset", testOn, 0);
    rst_n = 1'b1;
    h1 = 0; h2 = 0;
    @(negedge clk);
    check("R1 colour after reset", colorIdx, 1);
  endtask

  task automatic t_rotate();
    int exp;
    exp = colorIdx;
    for (int i = 0; i < 7; i++) begin
      tickTag("R7 tag during rotation");
      exp = (exp + 1) % 3;
      check("R2 rotation", colorIdx, exp);
      check("R8 gain", gainCode, gainRegs[exp*GW +: GW]);
      check("R8 offset", offsetCode, offsetRegs[exp*OW +: OW]);
    end
  endtask

  task automatic t_lineStart();
    int c0;
    while (colorIdx != 2'd1) tick();
    c0 = colorIdx;
    lineStartN = 1'b0;
    tickTag("R7 tag at line start");
    check("R3 first edge still rotates", colorIdx, (c0 + 1) % 3);
    tickTag("R7 tag at line start");
    check("R3 forced red", colorIdx, 0);
    tickTag("R7 tag held red");
    check("R3 held red", colorIdx, 0);
    lineStartN = 1'b1;
    tickTag("R7 tag at release");
    check("R3 red one edge after release", colorIdx, 0);
    tickTag("R7 tag after release");
    check("R3 resume green", colorIdx, 1);
  endtask

  task automatic t_single();
    threeChanMode = 1'b0;
    lineStartN = 1'b0;
    cfgColor = 2'd2; tick();
    check("R4 fixed blue", colorIdx, 2);
    tick(); tick();
    check("R4 line start ignored", colorIdx, 2);
    check("R8 gain blue", gainCode, 21);
    cfgColor = 2'd1; tick();
    check("R4 fixed green", colorIdx, 1);
    lineStartN = 1'b1;
    cfgColor = 2'd3; tick();
    check("R6 cfg reserved holds", colorIdx, 1);
    check("R6 cfg reserved err", colorErr, 1);
    cfgColor = 2'd0; tick();
    check("R6 err clears", colorErr, 0);
    check("R4 fixed red", colorIdx, 0);
    threeChanMode = 1'b1;
  endtask

  task automatic t_ext();
    lineStartN = 1'b0;
    extCtlN = 1'b0;
    extColor = 2'd2; tick();
    check("R5 override blue", colorIdx, 2);
    tick(); tick();
    check("R5 override beats line start", colorIdx, 2);
    lineStartN = 1'b1;
    extColor = 2'd1; tick();
    check("R5 override green", colorIdx, 1);
    tick();
    check("R5 override beats rotation", colorIdx, 1);
    extColor = 2'd3; tick();
    check("R6 ext reserved holds", colorIdx, 1);
    check("R6 ext reserved err", colorErr, 1);
    extColor = 2'd0; extCtlN = 1'b1; tick();
    check("R6 err clears after ext", colorErr, 0);
  endtask

  task automatic t_test();
    testCtlN = 1'b0; testSel = 2'd2; tick();
    check("R9 test chan", testChan, 2);
    check("R9 testOn", testOn, 1);
    testSel = 2'd3; tick();
    check("R9 reserved holds", testChan, 2);
    check("R9 reserved err", colorErr, 1);
    testSel = 2'd1; tick();
    check("R9 test chan green", testChan, 1);
    testCtlN = 1'b1; tick();
    check("R9 testOn off", testOn, 0);
    check("R9 chan kept", testChan, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_rotate();
    t_lineStart();
    t_single();
    t_ext();
    t_rotate();
    t_test();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule